// File: doc/BRIEF.md
# Serial Port Frame Sync Generator

This block produces the frame sync pulse of a one-direction synchronous serial port and shifts data words in step with it. A static direction bit picks transmit or receive. A static mode bit picks the framing policy for that direction. In free-running framing a sync pulse starts a frame at every programmed interval, whatever the buffer holds. In buffer-gated framing a frame starts only when the one-word buffer allows it: in transmit, when a word is waiting; in receive, when there is space for the next word.

The serial bit rate comes from a clock enable, `sclk_en`. Each system clock edge with the enable high ends one serial cycle. Words are 3 to 32 bits long and travel MSB first. The frame interval is a count of serial cycles. A sync position bit places the sync on the first data bit (late framing) or one serial cycle ahead of it (early framing).

Words move in through a valid/ready write port and out through a valid/ready read port. A write is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low while the transmit buffer holds a word, so the writer must hold its word until then. The received word stays on `rx_data` with `rx_valid` high until an edge with `rx_ready` high. The port cannot apply back-pressure to the serial line, so a receive word that finds the buffer still full is lost and flagged.

Top module: `sport_fsync_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `fs_out` and `sd_out` are 0, `tx_ready` is 1, `rx_valid` is 0 and both sticky flags are 0.
- R2: With `cfg_free_run`=1, frames start every `cfg_period` serial cycles with no gaps, whatever the buffer state. `fs_out` is 1 for exactly the first serial cycle of each frame.
- R3: With `cfg_free_run`=0 and `cfg_tx`=1, a frame starts at an interval boundary only if the transmit buffer holds a word. Otherwise the port idles and rechecks at every serial cycle.
- R4: With `cfg_free_run`=0 and `cfg_tx`=0, a frame starts at an interval boundary only if the receive buffer is empty (`rx_valid`=0).
- R5: With `cfg_early`=0, the MSB goes out (or is sampled) in the same serial cycle in which `fs_out` is 1. With `cfg_early`=1, that happens in the following serial cycle. Early framing needs `cfg_period` >= `cfg_word_len`+1, and late framing needs `cfg_period` >= `cfg_word_len`.
- R6: A transmitted word occupies `cfg_word_len` consecutive serial cycles, MSB first. `sd_out` is 0 outside that window and always 0 in receive mode.
- R7: The transmit buffer is emptied only when its word moves into the shifter at a frame start. It is never emptied in mid-frame. `tx_ready` stays 0 from the accepting edge until that frame start.
- R8: A free-running transmit frame that starts with an empty buffer sends all zeros and sets `tx_underflow`, which stays 1 until reset.
- R9: `sd_in` is sampled at the end of each data serial cycle. After the last bit, the word appears right-aligned on `rx_data` with `rx_valid`=1, and it stays there until an edge with `rx_ready`=1.
- R10: If a received word completes while the buffer is full and is not being read on that edge, the new word is dropped, the buffer keeps its old word, and `rx_overflow` is set and stays 1 until reset.
- R11: `fs_out` and `sd_out` change only on clock edges with `sclk_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_en | input | 1 | Serial cycle enable; one serial cycle ends per clock edge with this high |
| cfg_tx | input | 1 | 1 = transmit, 0 = receive |
| cfg_free_run | input | 1 | 1 = free-running framing, 0 = buffer-gated framing |
| cfg_early | input | 1 | 1 = sync one serial cycle before the MSB, 0 = sync on the MSB |
| cfg_word_len | input | 6 | Bits per word, 3 to 32 |
| cfg_period | input | 9 | Frame interval in serial cycles, up to 256 |
| fs_out | output | 1 | Frame sync, active high, one serial cycle long |
| sd_out | output | 1 | Serial data out |
| sd_in | input | 1 | Serial data in |
| tx_valid | input | 1 | Write request for the transmit buffer |
| tx_ready | output | 1 | Transmit buffer is empty and can take a word |
| tx_data | input | 32 | Word to transmit, right-aligned |
| rx_valid | output | 1 | Receive buffer holds a word |
| rx_ready | input | 1 | Reader takes the word on this edge |
| rx_data | output | 32 | Received word, right-aligned |
| tx_underflow | output | 1 | Sticky: a free-running transmit frame started with no word |
| rx_overflow | output | 1 | Sticky: a received word was dropped |

## Verification
A frame counter that drifts shows up within one interval as a sync pulse at the wrong serial cycle, and the data window moves with it. A buffer-full bit that is wrong shows up at the next interval boundary. It either starts a gated frame that should not start, or suppresses one that should, and the ready or valid port disagrees in the same clock. A misaligned shifter corrupts `sd_out` from the first data bit. A wrong receive assembly appears on `rx_data` as soon as the word completes. The bench compares every port against a bit-index reference model on every clock, so each of these faults is caught in the clock where it first becomes visible.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

  // Serial cycles between the sync cycle and the first data bit.
  function automatic int lead_cycles(logic early);
    return early ? 1 : 0;
  endfunction

  // True when phase ph of a frame carries a data bit.
  function automatic logic in_window(int ph, int wl, logic early);
    int off;
    off = lead_cycles(early);
    return (ph >= off) && (ph < wl + off);
  endfunction

  // True when phase ph of a frame carries the last data bit.
  function automatic logic is_last(int ph, int wl, logic early);
    return ph == (wl - 1 + lead_cycles(early));
  endfunction

endpackage

// File: rtl/sfg_frame_timer.sv
module sfg_frame_timer #(
  parameter int PW  = 9,
  parameter int WLW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           start_ok,
  input  logic           cfg_early,
  input  logic [WLW-1:0] cfg_word_len,
  input  logic [PW-1:0]  cfg_period,
  output logic           frame_start,
  output logic           win_now,
  output logic           last_now,
  output logic           win_next,
  output logic           fs_out
);
  import sfg_pkg::*;

  logic          run_q, run_d;
  logic [PW-1:0] ph_q, ph_d;
  logic          at_edge;

  always_comb begin
    // At an interval boundary (or when idle) the next serial cycle may open a frame.
    at_edge     = !run_q || (ph_q == cfg_period - PW'(1));
    frame_start = tick && at_edge && start_ok;
    ph_d        = at_edge ? '0 : ph_q + PW'(1);
    run_d       = at_edge ? start_ok : run_q;
    win_now     = run_q && in_window(int'(ph_q), int'(cfg_word_len), cfg_early);
    last_now    = run_q && is_last(int'(ph_q), int'(cfg_word_len), cfg_early);
    win_next    = run_d && in_window(int'(ph_d), int'(cfg_word_len), cfg_early);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ph_q   <= '0;
      fs_out <= 1'b0;
    end else if (tick) begin
      run_q  <= run_d;
      ph_q   <= ph_d;
      fs_out <= frame_start;
    end
  end

endmodule

// File: rtl/sfg_tx_path.sv
module sfg_tx_path #(
  parameter int W   = 32,
  parameter int WLW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           enable,
  input  logic           frame_start,
  input  logic           win_next,
  input  logic           cfg_early,
  input  logic [WLW-1:0] cfg_word_len,
  input  logic           tx_valid,
  input  logic [W-1:0]   tx_data,
  output logic           tx_ready,
  output logic           tx_full,
  output logic           sd_out,
  output logic           underflow
);

  logic [W-1:0] hold_q;
  logic [W-1:0] sh_q;
  logic [W-1:0] load_word;
  logic [W-1:0] aligned;
  logic         full_q;

  always_comb begin
    load_word = full_q ? hold_q : '0;
    // Left-justify so the word's MSB sits at the shifter's top bit.
    aligned   = load_word << (W - int'(cfg_word_len));
  end

  assign tx_ready = !full_q;
  assign tx_full  = full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      sh_q      <= '0;
      full_q    <= 1'b0;
      sd_out    <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (tick && enable) begin
        if (frame_start) begin
          full_q <= 1'b0;
          if (!full_q) underflow <= 1'b1;
          if (cfg_early) begin
            sd_out <= 1'b0;
            sh_q   <= aligned;
          end else begin
            sd_out <= aligned[W-1];
            sh_q   <= aligned << 1;
          end
        end else if (win_next) begin
          sd_out <= sh_q[W-1];
          sh_q   <= sh_q << 1;
        end else begin
          sd_out <= 1'b0;
        end
      end
      // Acceptance comes last so a word arriving on a frame-start edge stays buffered.
      if (tx_valid && !full_q) begin
        hold_q <= tx_data;
        full_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sfg_rx_path.sv
module sfg_rx_path #(
  parameter int W   = 32,
  parameter int WLW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           enable,
  input  logic           win_now,
  input  logic           last_now,
  input  logic [WLW-1:0] cfg_word_len,
  input  logic           sd_in,
  input  logic           rx_ready,
  output logic           rx_valid,
  output logic [W-1:0]   rx_data,
  output logic           rx_full,
  output logic           overflow
);

  logic [W-1:0] sh_q;
  logic [W-1:0] hold_q;
  logic [W-1:0] cap;
  logic [W-1:0] mask;
  logic         full_q;
  logic         done;

  always_comb begin
    cap  = {sh_q[W-2:0], sd_in};
    mask = {W{1'b1}} >> (W - int'(cfg_word_len));
    done = tick && enable && last_now;
  end

  assign rx_valid = full_q;
  assign rx_full  = full_q;
  assign rx_data  = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      hold_q   <= '0;
      full_q   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (tick && enable && win_now) sh_q <= cap;
      if (done && full_q && !rx_ready) begin
        overflow <= 1'b1;
      end else if (done) begin
        hold_q <= cap & mask;
        full_q <= 1'b1;
      end else if (rx_ready && full_q) begin
        full_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sport_fsync_gen.sv
module sport_fsync_gen #(
  parameter  int MAX_WORD   = 32,
  parameter  int MAX_PERIOD = 256,
  localparam int WLW        = $clog2(MAX_WORD + 1),
  localparam int PW         = $clog2(MAX_PERIOD + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_en,
  input  logic                cfg_tx,
  input  logic                cfg_free_run,
  input  logic                cfg_early,
  input  logic [WLW-1:0]      cfg_word_len,
  input  logic [PW-1:0]       cfg_period,
  output logic                fs_out,
  output logic                sd_out,
  input  logic                sd_in,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [MAX_WORD-1:0] tx_data,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic [MAX_WORD-1:0] rx_data,
  output logic                tx_underflow,
  output logic                rx_overflow
);

  logic frame_start, win_now, last_now, win_next;
  logic tx_full, rx_full, start_ok;

  // Gate: free-running always opens; otherwise the active buffer must permit it.
  assign start_ok = cfg_free_run | (cfg_tx ? tx_full : !rx_full);

  sfg_frame_timer #(.PW(PW), .WLW(WLW)) u_timer (
    .clk, .rst_n, .tick(sclk_en), .start_ok, .cfg_early, .cfg_word_len,
    .cfg_period, .frame_start, .win_now, .last_now, .win_next, .fs_out
  );

  sfg_tx_path #(.W(MAX_WORD), .WLW(WLW)) u_tx (
    .clk, .rst_n, .tick(sclk_en), .enable(cfg_tx), .frame_start, .win_next,
    .cfg_early, .cfg_word_len, .tx_valid, .tx_data, .tx_ready, .tx_full,
    .sd_out, .underflow(tx_underflow)
  );

  sfg_rx_path #(.W(MAX_WORD), .WLW(WLW)) u_rx (
    .clk, .rst_n, .tick(sclk_en), .enable(!cfg_tx), .win_now, .last_now,
    .cfg_word_len, .sd_in, .rx_ready, .rx_valid, .rx_data, .rx_full,
    .overflow(rx_overflow)
  );

endmodule

// File: rtl/sfg_checker.sv
module sfg_checker (
  input logic clk,
  input logic rst_n,
  input logic sclk_en,
  input logic cfg_tx,
  input logic cfg_free_run,
  input logic fs_out,
  input logic sd_out,
  input logic tx_ready,
  input logic rx_valid,
  input logic tx_underflow,
  input logic rx_overflow
);

  p_fs_one_serial_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_en && fs_out) |=> !fs_out);

  p_tx_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fs_out) && cfg_tx && !cfg_free_run) |-> $past(!tx_ready));

  p_rx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fs_out) && !cfg_tx && !cfg_free_run) |-> $past(!rx_valid));

  p_rx_mode_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tx |-> !sd_out);

  p_tx_drain_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fs_out) && cfg_tx && !cfg_free_run) |-> tx_ready);

  p_underflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underflow |=> tx_underflow);

  p_overflow_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |=> rx_overflow);

  p_hold_without_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_en |=> ($stable(fs_out) && $stable(sd_out)));

endmodule

bind sport_fsync_gen sfg_checker u_sfg_checker (
  .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .cfg_tx(cfg_tx),
  .cfg_free_run(cfg_free_run), .fs_out(fs_out), .sd_out(sd_out),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .tx_underflow(tx_underflow),
  .rx_overflow(rx_overflow)
);

// File: tb/sport_fsync_gen_bench.sv
`timescale 1ns/1ps
module sport_fsync_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_en = 1'b0;
  logic        cfg_tx = 1'b1, cfg_free_run = 1'b1, cfg_early = 1'b0;
  logic [5:0]  cfg_word_len = 6'd8;
  logic [8:0]  cfg_period = 9'd10;
  logic        fs_out, sd_out, sd_in = 1'b0;
  logic        tx_valid = 1'b0, tx_ready;
  logic [31:0] tx_data = '0;
  logic        rx_valid, rx_ready = 1'b0;
  logic [31:0] rx_data;
  logic        tx_underflow, rx_overflow;

  always #2 clk = ~clk;

  sport_fsync_gen u_sport_fsync_gen (
    .clk, .rst_n, .sclk_en, .cfg_tx, .cfg_free_run, .cfg_early, .cfg_word_len,
    .cfg_period, .fs_out, .sd_out, .sd_in, .tx_valid, .tx_ready, .tx_data,
    .rx_valid, .rx_ready, .rx_data, .tx_underflow, .rx_overflow
  );

  int checks = 0;
  int errors = 0;
  bit cmp_en = 0;
  bit done = 0;
  string tag_fs = "R2";
  string tag_sd = "R6";

  // Reference model state: frame phase, buffers as plain values, bit by index.
  int              m_ph, m_k, m_wl, m_per, m_off;
  bit              m_run, m_fs, m_sd, m_txf, m_rxf, m_unf, m_ovf, m_tick;
  bit              m_rd, m_wr, m_newfull, m_ok;
  longint unsigned m_txw, m_cur, m_rxw, m_acc;
  bit              prev_fs, prev_sd;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_run = 0; m_fs = 0; m_sd = 0; m_txf = 0; m_rxf = 0;
      m_unf = 0; m_ovf = 0; m_txw = 0; m_cur = 0; m_rxw = 0; m_acc = 0; m_tick = 0;
    end else begin
      m_wl = int'(cfg_word_len); m_per = int'(cfg_period); m_off = cfg_early ? 1 : 0;
      m_rd = rx_ready && m_rxf;
      m_wr = tx_valid && !m_txf;
      m_newfull = 0;
      m_tick = sclk_en;
      if (sclk_en) begin
        if (m_run && !cfg_tx) begin
          m_k = m_ph - m_off;
          if (m_k >= 0 && m_k < m_wl) begin
            m_acc = (m_acc << 1) | longint'(sd_in);
            if (m_k == m_wl - 1) begin
              if (m_rxf && !m_rd) m_ovf = 1;
              else begin
                m_rxw = m_acc & ((64'd1 << m_wl) - 1);
                m_newfull = 1;
              end
            end
          end
        end
        if (!m_run || m_ph == m_per - 1) begin
          m_ok = cfg_free_run ? 1'b1 : (cfg_tx ? m_txf : !m_rxf);
          m_ph = 0; m_run = m_ok; m_fs = m_ok;
          if (m_ok && cfg_tx) begin
            if (m_txf) m_cur = m_txw;
            else begin m_cur = 0; m_unf = 1; end
            m_txf = 0;
          end
        end else begin
          m_ph++; m_fs = 0;
        end
        m_sd = 0;
        if (cfg_tx && m_run) begin
          m_k = m_ph - m_off;
          if (m_k >= 0 && m_k < m_wl) m_sd = bit'((m_cur >> (m_wl - 1 - m_k)) & 1);
        end
      end
      if (m_newfull) m_rxf = 1;
      else if (m_rd) m_rxf = 0;
      if (m_wr) begin m_txf = 1; m_txw = longint'(tx_data); end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(tag_fs, "fs_out", longint'(fs_out), longint'(m_fs));
      chk(tag_sd, "sd_out", longint'(sd_out), longint'(m_sd));
      chk("R7", "tx_ready", longint'(tx_ready), longint'(!m_txf));
      chk("R9", "rx_valid", longint'(rx_valid), longint'(m_rxf));
      if (m_rxf) chk("R9", "rx_data", longint'(rx_data), longint'(m_rxw));
      chk("R8", "tx_underflow", longint'(tx_underflow), longint'(m_unf));
      chk("R10", "rx_overflow", longint'(rx_overflow), longint'(m_ovf));
      if (!m_tick) begin
        chk("R11", "fs_out hold", longint'(fs_out), longint'(prev_fs));
        chk("R11", "sd_out hold", longint'(sd_out), longint'(prev_sd));
      end
    end
    prev_fs = fs_out;
    prev_sd = sd_out;
  end

  task automatic run_scen(bit tx, bit free, bit early, int wl, int per, int div,
                          int wprob, int rprob, int ncyc, string tfs, string tsd);
    @(posedge clk); #1;
    cmp_en = 0; rst_n = 0;
    cfg_tx = tx; cfg_free_run = free; cfg_early = early;
    cfg_word_len = 6'(wl); cfg_period = 9'(per);
    sclk_en = 0; tx_valid = 0; rx_ready = 0; sd_in = 0;
    tag_fs = tfs; tag_sd = tsd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", "fs_out after reset", longint'(fs_out), 0);
    chk("R1", "sd_out after reset", longint'(sd_out), 0);
    chk("R1", "tx_ready after reset", longint'(tx_ready), 1);
    chk("R1", "rx_valid after reset", longint'(rx_valid), 0);
    chk("R1", "flags after reset", longint'({tx_underflow, rx_overflow}), 0);
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk); #1;
      cmp_en  = 1;
      sclk_en = (c % div) == 0;
      tx_valid = ($urandom % wprob) == 0;
      tx_data  = $urandom;
      rx_ready = ($urandom % rprob) == 0;
      sd_in    = 1'($urandom % 2);
    end
  endtask

  initial begin
    // Free-running transmit, late sync, sparse writes: R2 and R8 underflow.
    run_scen(1, 1, 0, 8, 10, 1, 25, 2, 1500, "R2", "R6");
    // Gated transmit, back-to-back interval, slow serial clock: R3 and R7.
    run_scen(1, 0, 0, 5, 5, 2, 6, 2, 2000, "R3", "R6");
    // Gated transmit, early sync, full 32-bit word: R5.
    run_scen(1, 0, 1, 32, 40, 1, 30, 2, 2500, "R5", "R5");
    // Gated receive with a slow reader: R4 and R9.
    run_scen(0, 0, 0, 12, 16, 1, 4, 20, 2500, "R4", "R6");
    // Free-running receive, early sync, shortest word, rare reads: R10 overflow.
    run_scen(0, 1, 1, 3, 4, 1, 4, 15, 1500, "R5", "R6");
    // Free-running receive at the longest interval: R2 and R9.
    run_scen(0, 1, 0, 16, 256, 1, 4, 3, 2000, "R2", "R6");
    // Free-running transmit, early sync, divided serial clock: R5, R8 and R11.
    run_scen(1, 1, 1, 3, 4, 3, 2, 2, 1500, "R5", "R5");
    @(posedge clk); #1;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before the run ended");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule